// File: doc/BRIEF.md
# I/Q Sample Input Demultiplexer

This block is the front end of a dual-channel transmit datapath. It accepts baseband I and Q samples in one of two arrangements, chosen at run time. In the dual-bus arrangement, each channel has its own input bus and a full pair is taken on every clock. In the single-bus arrangement, one bus carries I and Q words in turn at twice the pair rate. The block splits that stream back into I/Q pairs, using a marker input to find the I word, and presents each pair at once.

Each word can be given in two's complement or in offset binary. A coding input selects which one is used. Offset-binary words are changed to two's complement as they are sampled. The output is a registered I/Q pair with a one-cycle valid strobe.

Top module: `iq_input_demux`

## Requirements
- R1: While rst_n is low at a clock edge, the edge drives out_valid to 0 and out_i and out_q to 0.
- R2: With mode_ilv = 0 (dual-bus), every edge samples bus_a as I and bus_b as Q. The pair appears on out_i/out_q after that same edge, with out_valid = 1.
- R3: With mode_ilv = 1 (single-bus), only bus_a carries data. A word sampled while sel_i is 1, when sel_i was 0 at the previous edge, is an I word and produces no output. The word at the next edge is its Q, and the pair appears after that edge with out_valid = 1 for that one cycle. bus_b has no effect.
- R4: Once aligned, words keep alternating I, Q, I, Q without any further marker, so the block delivers at most one pair every two clocks.
- R5: After reset, or after entering single-bus mode, no pair is delivered until a rising marker has been seen.
- R6: A rising marker that arrives while an I word is held discards the held word. The marked word becomes the new I, so a Q word is never paired with an older I.
- R7: With fmt_offset = 1, the MSB of each word is inverted when the word is sampled (offset binary to two's complement). With fmt_offset = 0, words pass through unchanged.
- R8: At an edge where mode_ilv differs from its value at the previous edge, out_valid goes to 0 and any half-received pair is dropped. Single-bus mode then needs a new rising marker.
- R9: While out_valid is 0, out_i and out_q keep the last values they were given.
- R10: Holding sel_i high over several words does not realign the stream. Only a 0-to-1 change of sel_i counts as a marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_ilv | input | 1 | 0 = two buses, 1 = one interleaved bus |
| fmt_offset | input | 1 | 1 = input words are offset binary, 0 = two's complement |
| bus_a | input | DW (10) | I bus in dual-bus mode; interleaved stream in single-bus mode |
| bus_b | input | DW (10) | Q bus in dual-bus mode; unused in single-bus mode |
| sel_i | input | 1 | Marker; a rising level flags an I word |
| out_valid | output | 1 | One-cycle strobe per delivered pair |
| out_i | output | DW (10) | I word of the pair, two's complement |
| out_q | output | DW (10) | Q word of the pair, two's complement |

## Verification
The bench builds the block with its default word width of 10 bits. At this width, the all-zero and all-one words show the MSB inversion at both ends of the range. Sign-boundary values such as 0x200 and 0x1FF show that only the top bit changes. The 10-bit bus also leaves room for distinct I and Q values in every pair. With these values, a swapped, stale or misaligned word shows up at the output as a wrong value.

// File: rtl/iqd_pkg.sv
// Shared encodings for the I/Q input demultiplexer.
package iqd_pkg;
    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_ILV  = 1'b1
    } mode_e;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;
endpackage

// File: rtl/iqd_fmt_conv.sv
// Word-format converter: turns an offset-binary word into two's complement.
// It does this by flipping the sign bit. Purely combinational.
// Assumes DW >= 2.
module iqd_fmt_conv #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] raw,
    input  logic          offset_en,
    output logic [DW-1:0] twos
);
    // Flip the MSB only when offset-binary coding is selected.
    always_comb begin
        twos         = raw;
        twos[DW-1]   = raw[DW-1] ^ offset_en;
    end
endmodule

// File: rtl/iqd_ilv_split.sv
// Interleaved-stream splitter. It tracks the I/Q phase of a single-bus stream.
// A rising marker aligns the stream, and the splitter holds each I word until its Q arrives.
// pair_fire is high in the cycle whose word is the Q that completes a pair.
// Assumes the word is already converted to two's complement.
// flush clears alignment and any held word.
module iqd_ilv_split #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [DW-1:0] word,
    input  logic          sel_i,
    output logic [DW-1:0] held_i,
    output logic          pair_fire
);
    logic sel_d;
    logic aligned;
    logic has_i;
    logic marker_rise;

    // Detect a 0-to-1 change of the marker.
    assign marker_rise = sel_i & ~sel_d;

    // The current word completes a pair when an I is held and no new marker overrides it.
    assign pair_fire = ~flush & ~marker_rise & has_i;

    // Remember the previous marker level.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_d <= 1'b0;
        else        sel_d <= sel_i;
    end

    // Phase tracking: align on a marker, then alternate I and Q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned <= 1'b0;
            has_i   <= 1'b0;
            held_i  <= '0;
        end else if (flush) begin
            aligned <= 1'b0;
            has_i   <= 1'b0;
        end else if (marker_rise) begin
            aligned <= 1'b1;
            has_i   <= 1'b1;
            held_i  <= word;
        end else if (has_i) begin
            has_i   <= 1'b0;
        end else if (aligned) begin
            has_i   <= 1'b1;
            held_i  <= word;
        end
    end

    // R4: two completed pairs never come back to back.
    p_pair_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fire |=> !pair_fire);

    // R5 / R8: after a flush, the next cycle cannot complete a pair.
    p_flush_no_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pair_fire);

    // R6: a pair completes only after an I word was taken on the previous edge.
    p_q_follows_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fire |-> ($past(rst_n) && !$past(flush) && !$past(pair_fire)));
endmodule

// File: rtl/iq_input_demux.sv
// I/Q input stage. It takes either two separate sample buses or one interleaved bus.
// Every word is converted to two's complement. A registered I/Q pair is presented
// with a one-cycle valid strobe.
// Assumes mode_ilv and fmt_offset are synchronous to clk.
// A change of mode_ilv drops any partial pair.
module iq_input_demux #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ilv,
    input  logic          fmt_offset,
    input  logic [DW-1:0] bus_a,
    input  logic [DW-1:0] bus_b,
    input  logic          sel_i,
    output logic          out_valid,
    output logic [DW-1:0] out_i,
    output logic [DW-1:0] out_q
);
    import iqd_pkg::*;

    localparam int NLANE = 2;

    logic [NLANE-1:0][DW-1:0] raw_w;
    logic [NLANE-1:0][DW-1:0] conv_w;
    logic                     mode_d;
    logic                     mode_chg;
    logic                     split_flush;
    logic [DW-1:0]            split_i;
    logic                     split_fire;
    logic                     is_ilv;
    logic                     offset_en;

    assign raw_w[0]  = bus_a;
    assign raw_w[1]  = bus_b;
    assign is_ilv    = (mode_e'(mode_ilv) == MODE_ILV);
    assign offset_en = (fmt_e'(fmt_offset) == FMT_OFFSET);

    // One format converter per input lane.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        iqd_fmt_conv #(.DW(DW)) u_conv (
            .raw       (raw_w[g]),
            .offset_en (offset_en),
            .twos      (conv_w[g])
        );
    end

    // Track the mode seen at the previous edge, so a mode switch can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_d <= 1'b0;
        else        mode_d <= mode_ilv;
    end

    assign mode_chg    = (mode_ilv != mode_d);
    assign split_flush = mode_chg | ~is_ilv;

    iqd_ilv_split #(.DW(DW)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (split_flush),
        .word      (conv_w[0]),
        .sel_i     (sel_i),
        .held_i    (split_i),
        .pair_fire (split_fire)
    );

    // Output register: choose the pair source by mode, and hold the data while not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else if (mode_chg) begin
            out_valid <= 1'b0;
        end else if (!is_ilv) begin
            out_valid <= 1'b1;
            out_i     <= conv_w[0];
            out_q     <= conv_w[1];
        end else if (split_fire) begin
            out_valid <= 1'b1;
            out_i     <= split_i;
            out_q     <= conv_w[0];
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R2: a steady dual-bus mode delivers a pair on every edge.
    p_dual_every_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ilv && !$past(mode_ilv)) |=> out_valid);

    // R8: the edge of a mode switch delivers nothing.
    p_switch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (mode_ilv != $past(mode_ilv))) |=> !out_valid);

    // R9: outputs are stable whenever no pair is delivered.
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/iq_input_demux_test.sv
`timescale 1ns/1ps
// Directed bench for iq_input_demux. Inputs are driven, and outputs sampled,
// 1 ns after each rising edge.
module iq_input_demux_test;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_ilv = 1'b0;
    logic          fmt_offset = 1'b0;
    logic [DW-1:0] bus_a = '0;
    logic [DW-1:0] bus_b = '0;
    logic          sel_i = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_i;
    logic [DW-1:0] out_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iq_input_demux #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .fmt_offset(fmt_offset),
        .bus_a(bus_a), .bus_b(bus_b), .sel_i(sel_i),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // Apply one word set, then wait for the edge that samples it.
    task automatic tick(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic s);
        bus_a = a; bus_b = b; sel_i = s;
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic v, input logic [DW-1:0] ei,
                       input logic [DW-1:0] eq);
        total++;
        if (out_valid !== v || out_i !== ei || out_q !== eq) begin
            bad++;
            $display("FAIL %s: got v=%0b i=%h q=%h, expected v=%0b i=%h q=%h",
                     req, out_valid, out_i, out_q, v, ei, eq);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        tick(10'h155, 10'h2AA, 1'b0);
        tick(10'h155, 10'h2AA, 1'b1);
        chk("R1 reset state", 1'b0, '0, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_dual;
        mode_ilv = 1'b0; fmt_offset = 1'b0;
        tick(10'd5, 10'd300, 1'b0);
        chk("R2 dual pair", 1'b1, 10'd5, 10'd300);
        tick(10'h3FF, 10'h200, 1'b1);
        chk("R2 dual pair extremes", 1'b1, 10'h3FF, 10'h200);
        fmt_offset = 1'b1;
        tick(10'h000, 10'h3FF, 1'b0);
        chk("R7 dual offset conversion", 1'b1, 10'h200, 10'h1FF);
    endtask

    task automatic t_enter_ilv;
        mode_ilv = 1'b1; fmt_offset = 1'b0;
        tick(10'd1, 10'd2, 1'b1);
        chk("R8 switch edge quiet", 1'b0, 10'h200, 10'h1FF);
        tick(10'd2, 10'd3, 1'b1);
        chk("R5 no marker edge yet", 1'b0, 10'h200, 10'h1FF);
        tick(10'd3, 10'd4, 1'b0);
        chk("R9 hold while unaligned", 1'b0, 10'h200, 10'h1FF);
    endtask

    task automatic t_ilv_basic;
        tick(10'd10, 10'd777, 1'b1);
        chk("R3 I word alone", 1'b0, 10'h200, 10'h1FF);
        tick(10'd20, 10'd555, 1'b0);
        chk("R3 first pair", 1'b1, 10'd10, 10'd20);
        tick(10'd30, 10'd1, 1'b0);
        chk("R9 hold between pairs", 1'b0, 10'd10, 10'd20);
        tick(10'd40, 10'd2, 1'b0);
        chk("R4 alternation without marker", 1'b1, 10'd30, 10'd40);
        tick(10'd50, 10'd0, 1'b1);
        chk("R4 I on marker", 1'b0, 10'd30, 10'd40);
        tick(10'd60, 10'd0, 1'b1);
        chk("R10 high level is not a marker", 1'b1, 10'd50, 10'd60);
        tick(10'd70, 10'd0, 1'b1);
        chk("R10 still I phase", 1'b0, 10'd50, 10'd60);
        tick(10'd80, 10'd0, 1'b1);
        chk("R10 pair under steady marker", 1'b1, 10'd70, 10'd80);
    endtask

    task automatic t_resync;
        tick(10'd100, 10'd0, 1'b0);
        chk("R6 I captured", 1'b0, 10'd70, 10'd80);
        tick(10'd110, 10'd0, 1'b1);
        chk("R6 marker replaces held I", 1'b0, 10'd70, 10'd80);
        tick(10'd120, 10'd0, 1'b0);
        chk("R6 pair uses new I", 1'b1, 10'd110, 10'd120);
    endtask

    task automatic t_ilv_fmt;
        fmt_offset = 1'b1;
        tick(10'h005, 10'h0, 1'b0);
        chk("R7 I taken", 1'b0, 10'd110, 10'd120);
        tick(10'h300, 10'h0, 1'b0);
        chk("R7 interleaved offset conversion", 1'b1, 10'h205, 10'h100);
    endtask

    task automatic t_flush;
        fmt_offset = 1'b0;
        tick(10'd7, 10'd0, 1'b0);
        chk("R8 I held before switch", 1'b0, 10'h205, 10'h100);
        mode_ilv = 1'b0;
        tick(10'd8, 10'd9, 1'b0);
        chk("R8 switch to dual quiet", 1'b0, 10'h205, 10'h100);
        tick(10'd11, 10'd12, 1'b0);
        chk("R2 dual after switch", 1'b1, 10'd11, 10'd12);
        mode_ilv = 1'b1;
        tick(10'd13, 10'd0, 1'b0);
        chk("R8 switch to interleaved quiet", 1'b0, 10'd11, 10'd12);
        tick(10'd14, 10'd0, 1'b0);
        chk("R5 no pair before marker", 1'b0, 10'd11, 10'd12);
        tick(10'd15, 10'd0, 1'b1);
        chk("R8 marker after flush", 1'b0, 10'd11, 10'd12);
        tick(10'd16, 10'd0, 1'b0);
        chk("R8 fresh pair after flush", 1'b1, 10'd15, 10'd16);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_dual();
        t_enter_ilv();
        t_ilv_basic();
        t_resync();
        t_ilv_fmt();
        t_flush();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end
endmodule